// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block keeps the interrupt presentation state for a single processor. It holds the current processor priority, the number of the one source that is pending, the priority of that pending source and a software inter-processor interrupt threshold. A source controller offers delivery requests, each a source number with a priority. The presenter either latches a request, which raises its single interrupt line to the processor, or hands it straight back with a reject strobe so that the source controller can offer it again later.

The processor works the block through four register operations. Accept reads the combined presentation word and takes the pending source. End-of-interrupt restores a priority and returns a source number to the source controller. Set-priority changes the current processor priority. Set-threshold arms or disarms the software interrupt. A pending source of lower standing is displaced and rejected when a better one arrives. The software interrupt takes part as a pseudo-source, numbered 2, whenever its threshold beats the current priority. When the presenter becomes free to take work, it pulses a resend request so that the source controller offers its held-back sources again.

A numerically lower priority is more favoured, and the all-ones priority means idle. At most one operation is handled per clock. Every output is registered and shows the result one cycle after the input was sampled.

Top module: `irq_presenter`

## Requirements
- R1: After reset the current priority is 0, the pending number is 0, the pending priority and the threshold are all ones, and `irq_out` is low, so a first accept returns a presentation word of 0.
- R2: A delivery request is rejected (`rej_valid` high, `rej_src` equal to the requested number) when its priority is greater than or equal to the current priority, or when a source is pending whose priority is less than or equal to the requested one.
- R3: A delivery request that is not rejected first rejects any source already pending, then becomes the pending source with its priority, and `irq_out` goes high.
- R4: Accept (`op_kind` 0) returns the presentation word {current priority in the top PRIO_W bits, pending number in the low SRC_W bits} on `rd_xirr` with `rd_valid`, lowers `irq_out`, copies the pending priority into the current priority, clears the pending number and sets the pending priority to idle.
- R5: Set-priority (`op_kind` 2, value in `op_data[PRIO_W-1:0]`) with a value below the old priority, while a source is pending whose priority is greater than or equal to the new value, clears the pending source, sets the pending priority to idle, lowers `irq_out` and rejects that source.
- R6: Set-priority with a value that is not below the old priority, while nothing is pending, pulses `resend_pulse`; if the threshold is below the new priority, the software interrupt check also runs.
- R7: Set-threshold (`op_kind` 3, value in `op_data[PRIO_W-1:0]`) stores the threshold. When it is below the current priority and the check does not hold off, the pending number becomes 2, the pending priority becomes the threshold, `irq_out` goes high, and any source that was pending is rejected.
- R8: The software interrupt check leaves all state alone and rejects nothing when a source is pending whose priority is less than or equal to the threshold.
- R9: End-of-interrupt (`op_kind` 1) loads `op_data[XIRR_W-1:SRC_W]` into the current priority and returns `op_data[SRC_W-1:0]` on `eoi_src` with `eoi_valid`. If nothing is pending it then does a resend: the software interrupt check runs when the threshold is below the new priority, and `resend_pulse` is pulsed.
- R10: A delivery request presented in the same cycle as a register operation is ignored: it produces no reject and changes no state.
- R11: `irq_out` is high exactly when a source number is pending, and the pending priority is idle whenever nothing is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A register operation is presented this cycle |
| op_kind | input | 2 | 0 accept, 1 end-of-interrupt, 2 set priority, 3 set threshold |
| op_data | input | XIRR_W | Operation value (word for end-of-interrupt, low PRIO_W bits otherwise) |
| req_valid | input | 1 | A delivery request is presented this cycle |
| req_src | input | SRC_W | Requested source number (nonzero) |
| req_prio | input | PRIO_W | Requested priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | `rd_xirr` holds an accept result |
| rd_xirr | output | XIRR_W | Presentation word returned by accept |
| rej_valid | output | 1 | Reject strobe to the source controller |
| rej_src | output | SRC_W | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt strobe to the source controller |
| eoi_src | output | SRC_W | Source number finished by end-of-interrupt |
| resend_pulse | output | 1 | Request for the source controller to offer held sources again |

## Verification
A directed sequence first walks the delivery rules with equal, better and worse priorities against a pending source. This separates the strict and non-strict comparisons of the reject rule and the displacement path. It then lowers and raises the current priority, to split the clearing branch from the resend branch, and arms the software interrupt both where it wins and where a better pending source holds it off. A long stream of random operations and requests follows, with priorities drawn from a narrow range. It often collides a request with an operation and often lets the threshold and the pending priority tie, and a behavioural model compares every output on every clock.

// File: rtl/icp_pkg.sv
package icp_pkg;

  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_EOI      = 2'd1,
    OP_SET_CPPR = 2'd2,
    OP_SET_MFRR = 2'd3
  } op_kind_e;

endpackage

// File: rtl/icp_deliver.sv
// Decides whether an offered source displaces the pending one.
module icp_deliver #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [SRC_W-1:0]  pend_src,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] new_prio,
  output logic              take,
  output logic              drop_old
);
  logic busy;
  logic beaten;

  always_comb begin
    busy     = |pend_src;
    beaten   = busy && (pend_prio <= new_prio);
    take     = (new_prio < cur_prio) && !beaten;
    drop_old = take && busy;
  end
endmodule

// File: rtl/icp_ipi_check.sv
// Software interrupt check: folds the threshold in as a pseudo-source.
module icp_ipi_check #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic              en,
  input  logic [SRC_W-1:0]  pend_src,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] thresh,
  output logic              load,
  output logic              drop_old
);
  logic busy;
  logic hold_off;

  always_comb begin
    busy     = |pend_src;
    hold_off = busy && (pend_prio <= thresh);
    load     = en && !hold_off;
    drop_old = load && busy;
  end
endmodule

// File: rtl/icp_next_state.sv
// Next-state and strobe logic for one presenter.
module icp_next_state
  import icp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int XIRR_W = PRIO_W + SRC_W
) (
  input  logic [PRIO_W-1:0] cppr,
  input  logic [SRC_W-1:0]  xisr,
  input  logic [PRIO_W-1:0] pend,
  input  logic [PRIO_W-1:0] mfrr,
  input  logic              irq,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [XIRR_W-1:0] op_data,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  output logic [PRIO_W-1:0] n_cppr,
  output logic [SRC_W-1:0]  n_xisr,
  output logic [PRIO_W-1:0] n_pend,
  output logic [PRIO_W-1:0] n_mfrr,
  output logic              n_irq,
  output logic              n_rd,
  output logic              n_rej,
  output logic [SRC_W-1:0]  n_rej_src,
  output logic              n_eoi,
  output logic [SRC_W-1:0]  n_eoi_src,
  output logic              n_resend
);
  localparam logic [PRIO_W-1:0] IDLE   = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  IPI_NR = SRC_W'(IPI_SRC);

  logic              busy;
  logic              dl_take, dl_drop;
  logic [PRIO_W-1:0] val;
  logic [PRIO_W-1:0] top_val;

  // stage one: the operation or request itself
  logic [PRIO_W-1:0] m_cppr, m_pend, m_mfrr;
  logic [SRC_W-1:0]  m_xisr;
  logic              m_irq, m_rej, m_want_ipi, m_resend;
  logic [SRC_W-1:0]  m_rej_src;

  logic ipi_load, ipi_drop;

  assign busy    = |xisr;
  assign val     = op_data[PRIO_W-1:0];
  assign top_val = op_data[XIRR_W-1 -: PRIO_W];

  icp_deliver #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_deliver (
    .cur_prio (cppr),
    .pend_src (xisr),
    .pend_prio(pend),
    .new_prio (req_prio),
    .take     (dl_take),
    .drop_old (dl_drop)
  );

  always_comb begin
    m_cppr     = cppr;
    m_xisr     = xisr;
    m_pend     = pend;
    m_mfrr     = mfrr;
    m_irq      = irq;
    m_rej      = 1'b0;
    m_rej_src  = '0;
    m_want_ipi = 1'b0;
    m_resend   = 1'b0;
    n_rd       = 1'b0;
    n_eoi      = 1'b0;
    n_eoi_src  = '0;
    if (op_valid) begin
      case (op_kind_e'(op_kind))
        OP_ACCEPT: begin
          n_rd   = 1'b1;
          m_irq  = 1'b0;
          m_cppr = pend;
          m_xisr = '0;
          m_pend = IDLE;
        end
        OP_EOI: begin
          m_cppr    = top_val;
          n_eoi     = 1'b1;
          n_eoi_src = op_data[SRC_W-1:0];
          if (!busy) begin
            m_resend   = 1'b1;
            m_want_ipi = mfrr < top_val;
          end
        end
        OP_SET_CPPR: begin
          m_cppr = val;
          if (val < cppr) begin
            if (busy && (val <= pend)) begin
              m_xisr    = '0;
              m_pend    = IDLE;
              m_irq     = 1'b0;
              m_rej     = 1'b1;
              m_rej_src = xisr;
            end
          end else if (!busy) begin
            m_resend   = 1'b1;
            m_want_ipi = mfrr < val;
          end
        end
        OP_SET_MFRR: begin
          m_mfrr     = val;
          m_want_ipi = val < cppr;
        end
        default: ;
      endcase
    end else if (req_valid) begin
      if (dl_take) begin
        m_xisr = req_src;
        m_pend = req_prio;
        m_irq  = 1'b1;
        if (dl_drop) begin
          m_rej     = 1'b1;
          m_rej_src = xisr;
        end
      end else begin
        m_rej     = 1'b1;
        m_rej_src = req_src;
      end
    end
  end

  icp_ipi_check #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_ipi (
    .en       (m_want_ipi),
    .pend_src (m_xisr),
    .pend_prio(m_pend),
    .thresh   (m_mfrr),
    .load     (ipi_load),
    .drop_old (ipi_drop)
  );

  // stage two: the software interrupt pseudo-source
  always_comb begin
    n_cppr    = m_cppr;
    n_mfrr    = m_mfrr;
    n_resend  = m_resend;
    n_xisr    = m_xisr;
    n_pend    = m_pend;
    n_irq     = m_irq;
    n_rej     = m_rej;
    n_rej_src = m_rej_src;
    if (ipi_load) begin
      n_xisr = IPI_NR;
      n_pend = m_mfrr;
      n_irq  = 1'b1;
      if (ipi_drop) begin
        n_rej     = 1'b1;
        n_rej_src = m_xisr;
      end
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import icp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int XIRR_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [XIRR_W-1:0] op_data,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              irq_out,
  output logic              rd_valid,
  output logic [XIRR_W-1:0] rd_xirr,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_pulse
);
  localparam logic [PRIO_W-1:0] IDLE = {PRIO_W{1'b1}};

  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;

  logic [PRIO_W-1:0] n_cppr, n_pend, n_mfrr;
  logic [SRC_W-1:0]  n_xisr, n_rej_src, n_eoi_src;
  logic              n_irq, n_rd, n_rej, n_eoi, n_resend;

  icp_next_state #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_ns (
    .cppr     (cppr_q),
    .xisr     (xisr_q),
    .pend     (pend_q),
    .mfrr     (mfrr_q),
    .irq      (irq_out),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_data  (op_data),
    .req_valid(req_valid),
    .req_src  (req_src),
    .req_prio (req_prio),
    .n_cppr   (n_cppr),
    .n_xisr   (n_xisr),
    .n_pend   (n_pend),
    .n_mfrr   (n_mfrr),
    .n_irq    (n_irq),
    .n_rd     (n_rd),
    .n_rej    (n_rej),
    .n_rej_src(n_rej_src),
    .n_eoi    (n_eoi),
    .n_eoi_src(n_eoi_src),
    .n_resend (n_resend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr_q       <= '0;
      xisr_q       <= '0;
      pend_q       <= IDLE;
      mfrr_q       <= IDLE;
      irq_out      <= 1'b0;
      rd_valid     <= 1'b0;
      rd_xirr      <= '0;
      rej_valid    <= 1'b0;
      rej_src      <= '0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      resend_pulse <= 1'b0;
    end else begin
      cppr_q       <= n_cppr;
      xisr_q       <= n_xisr;
      pend_q       <= n_pend;
      mfrr_q       <= n_mfrr;
      irq_out      <= n_irq;
      rd_valid     <= n_rd;
      if (n_rd) rd_xirr <= {cppr_q, xisr_q};
      rej_valid    <= n_rej;
      rej_src      <= n_rej_src;
      eoi_valid    <= n_eoi;
      eoi_src      <= n_eoi_src;
      resend_pulse <= n_resend;
    end
  end

  // R1: state seen right after reset is released
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cppr_q == '0 && xisr_q == '0 && pend_q == IDLE &&
                    mfrr_q == IDLE && !irq_out));

  // R11: line follows the pending number; idle priority when empty
  assert_irq_tracks_pending_R11: assert property (@(posedge clk) disable iff (rst)
    irq_out == (xisr_q != '0));
  assert_idle_when_empty_R11: assert property (@(posedge clk) disable iff (rst)
    (xisr_q == '0) |-> (pend_q == IDLE));

  // R2: a request no better than the current priority bounces
  assert_reject_rule_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !op_valid && req_prio >= cppr_q)
      |=> (rej_valid && rej_src == $past(req_src) && xisr_q == $past(xisr_q)));

  // R4: accept clears the pending source and adopts its priority
  assert_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_ACCEPT)
      |=> (rd_valid && !irq_out && xisr_q == '0 && cppr_q == $past(pend_q)));

  // R5: lowering the priority under a weaker pending source drops it
  assert_cppr_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_SET_CPPR && op_data[PRIO_W-1:0] < cppr_q &&
     xisr_q != '0 && op_data[PRIO_W-1:0] <= pend_q)
      |=> (rej_valid && rej_src == $past(xisr_q) && !irq_out));

  // R7: a winning threshold loads the pseudo-source
  assert_ipi_load_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_SET_MFRR && op_data[PRIO_W-1:0] < cppr_q &&
     (xisr_q == '0 || pend_q > op_data[PRIO_W-1:0]))
      |=> (xisr_q == SRC_W'(IPI_SRC) && pend_q == $past(op_data[PRIO_W-1:0]) && irq_out));

  // R9: end-of-interrupt forwards the number and restores the priority
  assert_eoi_forward_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_EOI)
      |=> (eoi_valid && eoi_src == $past(op_data[SRC_W-1:0]) &&
           cppr_q == $past(op_data[XIRR_W-1 -: PRIO_W])));

  // R10: a request beside a threshold write that cannot load is ignored
  assert_request_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == OP_SET_MFRR && req_valid &&
     !(op_data[PRIO_W-1:0] < cppr_q))
      |=> (!rej_valid && xisr_q == $past(xisr_q)));
endmodule

// File: tb/tb_irq_presenter.sv
`timescale 1ns/1ps
module tb_irq_presenter;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int XIRR_W = PRIO_W + SRC_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              op_valid = 1'b0;
  logic [1:0]        op_kind = 2'd0;
  logic [XIRR_W-1:0] op_data = '0;
  logic              req_valid = 1'b0;
  logic [SRC_W-1:0]  req_src = '0;
  logic [PRIO_W-1:0] req_prio = '0;
  logic              irq_out, rd_valid, rej_valid, eoi_valid, resend_pulse;
  logic [XIRR_W-1:0] rd_xirr;
  logic [SRC_W-1:0]  rej_src, eoi_src;

  irq_presenter #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(2)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_data(op_data), .req_valid(req_valid), .req_src(req_src),
    .req_prio(req_prio), .irq_out(irq_out), .rd_valid(rd_valid),
    .rd_xirr(rd_xirr), .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_pulse(resend_pulse)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  string tag = "R1";

  // behavioural reference model
  int m_cppr, m_xisr, m_pend, m_mfrr;
  bit m_irq;
  bit e_rd, e_rej, e_eoi, e_rs;
  int e_rdw, e_rejs, e_eois;

  task automatic mdl_reject(int n);
    e_rej  = 1'b1;
    e_rejs = n;
  endtask

  task automatic mdl_ipi();
    if (m_xisr != 0 && m_pend <= m_mfrr) return;
    if (m_xisr != 0) mdl_reject(m_xisr);
    m_xisr = 2;
    m_pend = m_mfrr;
    m_irq  = 1'b1;
  endtask

  task automatic mdl_resend();
    if (m_mfrr < m_cppr) mdl_ipi();
    e_rs = 1'b1;
  endtask

  always @(posedge clk) begin
    int v;
    e_rd = 0; e_rej = 0; e_eoi = 0; e_rs = 0;
    if (rst) begin
      m_cppr = 0; m_xisr = 0; m_pend = 255; m_mfrr = 255; m_irq = 0;
      e_rdw = 0; e_rejs = 0; e_eois = 0;
    end else if (op_valid) begin
      case (op_kind)
        2'd0: begin
          e_rd = 1; e_rdw = (m_cppr << 24) | m_xisr;
          m_irq = 0; m_cppr = m_pend; m_xisr = 0; m_pend = 255;
        end
        2'd1: begin
          m_cppr = int'(op_data[31:24]);
          e_eoi = 1; e_eois = int'(op_data[23:0]);
          if (m_xisr == 0) mdl_resend();
        end
        2'd2: begin
          v = int'(op_data[7:0]);
          if (v < m_cppr) begin
            m_cppr = v;
            if (m_xisr != 0 && v <= m_pend) begin
              mdl_reject(m_xisr);
              m_xisr = 0; m_pend = 255; m_irq = 0;
            end
          end else begin
            m_cppr = v;
            if (m_xisr == 0) mdl_resend();
          end
        end
        default: begin
          m_mfrr = int'(op_data[7:0]);
          if (m_mfrr < m_cppr) mdl_ipi();
        end
      endcase
    end else if (req_valid) begin
      v = int'(req_prio);
      if (v >= m_cppr || (m_xisr != 0 && m_pend <= v)) begin
        mdl_reject(int'(req_src));
      end else begin
        if (m_xisr != 0) mdl_reject(m_xisr);
        m_xisr = int'(req_src); m_pend = v; m_irq = 1;
      end
    end
  end

  task automatic cmp(string t, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", t, what, got, exp);
    end
  endtask

  task automatic compare_model();
    cmp(tag, "irq_out", int'(irq_out), int'(m_irq));
    cmp(tag, "rd_valid", int'(rd_valid), int'(e_rd));
    if (e_rd) cmp(tag, "rd_xirr", int'(rd_xirr), e_rdw);
    cmp(tag, "rej_valid", int'(rej_valid), int'(e_rej));
    if (e_rej) cmp(tag, "rej_src", int'(rej_src), e_rejs);
    cmp(tag, "eoi_valid", int'(eoi_valid), int'(e_eoi));
    if (e_eoi) cmp(tag, "eoi_src", int'(eoi_src), e_eois);
    cmp(tag, "resend_pulse", int'(resend_pulse), int'(e_rs));
  endtask

  task automatic cyc(string t, bit ov, int ok, int od, bit rv, int rs, int rp);
    tag       = t;
    op_valid  = ov;
    op_kind   = 2'(ok);
    op_data   = XIRR_W'(od);
    req_valid = rv;
    req_src   = SRC_W'(rs);
    req_prio  = PRIO_W'(rp);
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic op(string t, int ok, int od);
    cyc(t, 1'b1, ok, od, 1'b0, 0, 0);
  endtask

  task automatic req(string t, int rs, int rp);
    cyc(t, 1'b0, 0, 0, 1'b1, rs, rp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc("R1", 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    cyc("R1", 0, 0, 0, 0, 0, 0);
    cmp("R1", "irq after reset", int'(irq_out), 0);
    op("R1", 0, 0);
    cmp("R1", "first accept word", int'(rd_xirr), 0);
    cmp("R1", "first accept valid", int'(rd_valid), 1);
    // current priority is now all ones
    req("R3", 'h10, 5);
    cmp("R3", "line raised", int'(irq_out), 1);
    cmp("R3", "no reject", int'(rej_valid), 0);
    req("R2", 'h11, 5);
    cmp("R2", "equal priority bounced", int'(rej_src), 'h11);
    req("R3", 'h12, 3);
    cmp("R3", "displaced source rejected", int'(rej_src), 'h10);
    cyc("R10", 1, 2, 4, 1, 'h13, 1);
    cmp("R10", "colliding request not rejected", int'(rej_valid), 0);
    op("R4", 0, 0);
    cmp("R4", "accept word", int'(rd_xirr), 'h04000012);
    cmp("R4", "line lowered", int'(irq_out), 0);
    req("R2", 'h14, 3);
    cmp("R2", "priority equal to current bounced", int'(rej_src), 'h14);
    req("R3", 'h15, 1);
    op("R5", 2, 1);
    cmp("R5", "pending dropped", int'(rej_src), 'h15);
    cmp("R5", "line lowered", int'(irq_out), 0);
    op("R6", 2, 'h20);
    cmp("R6", "resend pulse", int'(resend_pulse), 1);
    op("R7", 3, 8);
    cmp("R7", "pseudo-source raises line", int'(irq_out), 1);
    req("R3", 'h16, 6);
    cmp("R3", "pseudo-source displaced", int'(rej_src), 2);
    op("R8", 3, 7);
    cmp("R8", "check holds off", int'(rej_valid), 0);
    op("R8", 0, 0);
    cmp("R8", "pending kept", int'(rd_xirr), 'h20000016);
    op("R9", 1, 'h20000016);
    cmp("R9", "eoi number", int'(eoi_src), 'h16);
    cmp("R9", "resend pulse", int'(resend_pulse), 1);
    cmp("R9", "pseudo-source after resend", int'(irq_out), 1);
    op("R7", 0, 0);
    cmp("R7", "pseudo-source word", int'(rd_xirr), 'h20000002);

    for (int i = 0; i < 6000; i++) begin
      int sel = $urandom_range(0, 9);
      int p   = ($urandom_range(0, 7) == 0) ? 255 : $urandom_range(0, 15);
      int s   = $urandom_range(1, 40);
      bit both = ($urandom_range(0, 4) == 0);
      case (sel)
        0:       cyc("R4", 1, 0, 0, both, s, p);
        1:       cyc("R9", 1, 1, (p << 24) | s, both, s, p);
        2, 3:    cyc("R5", 1, 2, p, both, s, p);
        4:       cyc("R7", 1, 3, p, both, s, p);
        default: req("R2", s, p);
      endcase
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule